// File: doc/BRIEF.md
# Staged I/O delay register bank

This block holds the tap settings for a two-lane DDR memory interface. A single-cycle write port loads 8-bit values into a shadow copy of every delay. There are per-lane output delays for the eight data bits, the strobe and the mask. There are per-lane input delays for the eight data bits and the strobe. There are 32 command/address output delays and one clock phase value. The delay outputs see none of these loads until a transfer is commanded.

A transfer copies every shadow value into the active registers in one clock edge, so the delay lines never see a half-updated set. Two things trigger a transfer: a write to the dedicated apply address, or a write to the phase address. A phase write loads the new phase and commits it together with all staged delays. A combinational read port returns the shadow contents. Training firmware can therefore stage and check a full set of values before it commits them.

Top module: `iodly_regbank`

## Requirements
- R1: A write to a delay entry updates only its shadow value; the active outputs (all delay vectors and `phase`) keep their values until the next transfer.
- R2: A write to address 0x61 (apply) copies every shadow delay and the shadow phase to the active outputs on that clock edge. The written data is ignored.
- R3: A write to address 0x60 loads the phase shadow and transfers it at once to `phase`, together with all staged delays.
- R4: Reading a delay address or 0x60 returns the shadow value last written there, in the same cycle.
- R5: Lane l (0 or 1) output entries sit at 0x20*l + i: i = 0..7 for the data bits, i = 8 for the strobe, i = 9 for the mask. Input entries sit at 0x20*l + 0x10 + i: i = 0..7 for the data bits, i = 8 for the strobe. Command/address entry c (0..31) sits at 0x40 + c.
- R6: Each output vector packs one 8-bit field per pin, with field k at bits [8k+7:8k]. Data fields are numbered lane*8 + bit, strobe and mask fields are numbered by lane, and command/address fields by c.
- R7: `updated` is high for exactly the one cycle after each transfer edge and low otherwise.
- R8: A synchronous reset clears all shadow values, all active outputs, the phase and `updated` to zero.
- R9: Reading any address outside R5, 0x60 and 0x61 returns zero, and so does reading 0x61. A write to such an address changes no stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 8 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Shadow value at rd_addr |
| dq_out_dly | output | 128 | Active data output delays |
| dqs_out_dly | output | 16 | Active strobe output delays |
| dm_out_dly | output | 16 | Active mask output delays |
| dq_in_dly | output | 128 | Active data input delays |
| dqs_in_dly | output | 16 | Active strobe input delays |
| ca_out_dly | output | 256 | Active command/address delays |
| phase | output | 8 | Active clock phase |
| updated | output | 1 | One-cycle pulse after a transfer |

## Verification
A phase write both loads a register and commits the whole bank in the same cycle. The bench stages a fresh pattern in every entry, leaves the active set holding an older pattern, and then writes the phase. It expects the new phase and every newly staged delay to appear on the outputs in that single cycle, with `updated` raised. The read port can also sample a shadow entry in the cycle that this entry is written. The bench reads only between edges and expects the pre-edge value up to the edge and the new value after it.

// File: rtl/iodly_regbank.sv
module iodly_regbank #(
  parameter int DW          = 8,
  parameter int AW          = 8,
  parameter int NLANE       = 2,
  parameter int DQ          = 8,
  parameter int NCA         = 32,
  parameter int LANE_STRIDE = 32,
  parameter int IN_OFS      = 16,
  parameter int CA_BASE     = 64,
  parameter int PHASE_ADDR  = 96,
  parameter int APPLY_ADDR  = 97
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [AW-1:0]             wr_addr,
  input  logic [DW-1:0]             wr_data,
  input  logic [AW-1:0]             rd_addr,
  output logic [DW-1:0]             rd_data,
  output logic [NLANE*DQ*DW-1:0]    dq_out_dly,
  output logic [NLANE*DW-1:0]       dqs_out_dly,
  output logic [NLANE*DW-1:0]       dm_out_dly,
  output logic [NLANE*DQ*DW-1:0]    dq_in_dly,
  output logic [NLANE*DW-1:0]       dqs_in_dly,
  output logic [NCA*DW-1:0]         ca_out_dly,
  output logic [DW-1:0]             phase,
  output logic                      updated
);
  localparam int NOUT  = DQ + 2;
  localparam int NIN   = DQ + 1;
  localparam int LSPAN = NOUT + NIN;
  localparam int NENT  = NLANE * LSPAN + NCA;
  localparam int IW    = $clog2(NENT);
  localparam logic [AW-1:0] PH_A = AW'(PHASE_ADDR);
  localparam logic [AW-1:0] AP_A = AW'(APPLY_ADDR);

  logic [DW-1:0] sh  [NENT];
  logic [DW-1:0] act [NENT];
  logic [DW-1:0] ph_sh;

  function automatic int dec(input logic [AW-1:0] a);
    int ai = int'(a);
    int idx = -1;
    for (int l = 0; l < NLANE; l++) begin
      int ob = LANE_STRIDE * l;
      if (ai >= ob && ai < ob + NOUT) idx = l * LSPAN + ai - ob;
      if (ai >= ob + IN_OFS && ai < ob + IN_OFS + NIN) idx = l * LSPAN + NOUT + ai - ob - IN_OFS;
    end
    if (ai >= CA_BASE && ai < CA_BASE + NCA) idx = NLANE * LSPAN + ai - CA_BASE;
    return idx;
  endfunction

  int widx, ridx;
  assign widx = dec(wr_addr);
  assign ridx = dec(rd_addr);

  wire wr_ph = wr_en && wr_addr == PH_A;
  wire wr_ap = wr_en && wr_addr == AP_A;

  assign rd_data = (ridx >= 0)       ? sh[ridx[IW-1:0]] :
                   (rd_addr == PH_A) ? ph_sh : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh      <= '{default: '0};
      act     <= '{default: '0};
      ph_sh   <= '0;
      phase   <= '0;
      updated <= 1'b0;
    end else begin
      updated <= wr_ph || wr_ap;
      if (wr_en && widx >= 0) sh[widx[IW-1:0]] <= wr_data;
      if (wr_ph) begin
        ph_sh <= wr_data;
        phase <= wr_data;
        act   <= sh;
      end
      if (wr_ap) begin
        phase <= ph_sh;
        act   <= sh;
      end
    end
  end

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    for (genvar b = 0; b < DQ; b++) begin : g_bit
      assign dq_out_dly[(l*DQ+b)*DW +: DW] = act[l*LSPAN + b];
      assign dq_in_dly [(l*DQ+b)*DW +: DW] = act[l*LSPAN + NOUT + b];
    end
    assign dqs_out_dly[l*DW +: DW] = act[l*LSPAN + DQ];
    assign dm_out_dly [l*DW +: DW] = act[l*LSPAN + DQ + 1];
    assign dqs_in_dly [l*DW +: DW] = act[l*LSPAN + NOUT + DQ];
  end

  for (genvar c = 0; c < NCA; c++) begin : g_ca
    assign ca_out_dly[c*DW +: DW] = act[NLANE*LSPAN + c];
  end
endmodule

// File: rtl/iodly_regbank_chk.sv
module iodly_regbank_chk #(
  parameter int DW = 8, parameter int AW = 8, parameter int NLANE = 2,
  parameter int DQ = 8, parameter int NCA = 32,
  parameter int PHASE_ADDR = 96, parameter int APPLY_ADDR = 97,
  parameter int GAP_ADDR = 10
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   wr_en,
  input logic [AW-1:0]          wr_addr,
  input logic [DW-1:0]          wr_data,
  input logic [AW-1:0]          rd_addr,
  input logic [DW-1:0]          rd_data,
  input logic [NLANE*DQ*DW-1:0] dq_out_dly,
  input logic [NLANE*DW-1:0]    dqs_out_dly,
  input logic [NLANE*DW-1:0]    dm_out_dly,
  input logic [NLANE*DQ*DW-1:0] dq_in_dly,
  input logic [NLANE*DW-1:0]    dqs_in_dly,
  input logic [NCA*DW-1:0]      ca_out_dly,
  input logic [DW-1:0]          phase,
  input logic                   updated
);
  wire cmd_ph = wr_en && wr_addr == AW'(PHASE_ADDR);
  wire cmd_ap = wr_en && wr_addr == AW'(APPLY_ADDR);
  wire [NLANE*DQ*DW*2 + NLANE*DW*3 + NCA*DW + DW - 1:0] outs =
    {dq_out_dly, dqs_out_dly, dm_out_dly, dq_in_dly, dqs_in_dly, ca_out_dly, phase};

  assert_outs_hold_R1: assert property (@(posedge clk) disable iff (rst)
    (!updated && !$past(rst)) |-> $stable(outs));

  assert_apply_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    cmd_ap |=> updated);

  assert_phase_commit_R3: assert property (@(posedge clk) disable iff (rst)
    cmd_ph |=> (updated && phase == $past(wr_data)));

  assert_no_spurious_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    !(cmd_ph || cmd_ap) |=> !updated);

  assert_reset_clears_R8: assert property (@(posedge clk)
    $past(rst) |-> (!updated && phase == '0 && outs == '0));

  assert_gap_reads_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_addr == AW'(GAP_ADDR) || rd_addr == AW'(APPLY_ADDR)) |-> rd_data == '0);
endmodule

bind iodly_regbank iodly_regbank_chk chk_i (.*);

// File: tb/iodly_regbank_tb.sv
module iodly_regbank_tb_top;
  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0;
  logic [7:0] wr_addr = '0, wr_data = '0, rd_addr = '0, rd_data;
  logic [127:0] dq_out_dly, dq_in_dly;
  logic [15:0]  dqs_out_dly, dm_out_dly, dqs_in_dly;
  logic [255:0] ca_out_dly;
  logic [7:0]   phase;
  logic         updated;

  int n_run = 0, n_fail = 0;
  logic [7:0] m_sh [256];
  logic [7:0] m_act [256];
  logic [7:0] m_ph_sh, m_ph_act;

  always #10 clk = ~clk;

  iodly_regbank dut_i (.*);

  function automatic bit mapped(input int a);
    int off = a % 32;
    if (a < 64) return (off < 10) || (off >= 16 && off < 25);
    return a >= 64 && a < 96;
  endfunction

  task automatic check8(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 8'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (mapped(a)) m_sh[a] = d;
    if (a == 96) begin m_ph_sh = d; m_ph_act = d; m_act = m_sh; end
    if (a == 97) begin m_ph_act = m_ph_sh; m_act = m_sh; end
  endtask

  task automatic check_outs(input string tag);
    for (int l = 0; l < 2; l++) begin
      for (int b = 0; b < 8; b++) begin
        check8({tag, " R5 R6 dq_out"}, dq_out_dly[(l*8+b)*8 +: 8], m_act[l*32+b]);
        check8({tag, " R5 R6 dq_in"},  dq_in_dly[(l*8+b)*8 +: 8],  m_act[l*32+16+b]);
      end
      check8({tag, " R5 R6 dqs_out"}, dqs_out_dly[l*8 +: 8], m_act[l*32+8]);
      check8({tag, " R5 R6 dm_out"},  dm_out_dly[l*8 +: 8],  m_act[l*32+9]);
      check8({tag, " R5 R6 dqs_in"},  dqs_in_dly[l*8 +: 8],  m_act[l*32+24]);
    end
    for (int c = 0; c < 32; c++) check8({tag, " R5 R6 ca_out"}, ca_out_dly[c*8 +: 8], m_act[64+c]);
    check8({tag, " phase"}, phase, m_ph_act);
  endtask

  task automatic check_rd(input string tag);
    for (int a = 0; a < 256; a++) begin
      @(negedge clk);
      rd_addr = 8'(a);
      #1;
      check8({tag, " R4 R9 readback"}, rd_data,
             mapped(a) ? m_sh[a] : (a == 96) ? m_ph_sh : 8'h00);
    end
  endtask

  initial begin
    #3_000_000;
    n_fail++;
    $display("FAIL watchdog: got hang expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int a = 0; a < 256; a++) begin m_sh[a] = '0; m_act[a] = '0; end
    m_ph_sh = '0; m_ph_act = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check8("R8 updated after reset", {7'd0, updated}, 8'h00);
    check_outs("R8 reset");
    check_rd("R8 reset");

    for (int a = 0; a < 96; a++) if (mapped(a)) begin
      wr(a, 8'(a * 3 + 1));
      check8("R7 no pulse on load", {7'd0, updated}, 8'h00);
    end
    check_outs("R1 staged only");
    check_rd("R4 pattern1");

    for (int a = 0; a < 256; a++) if (!mapped(a) && a != 96 && a != 97) wr(a, 8'hA5);
    check_rd("R9 unmapped writes");
    check_outs("R9 unmapped writes");

    wr(97, 8'h5A);
    check8("R2 R7 updated after apply", {7'd0, updated}, 8'h01);
    check_outs("R2 apply");
    @(negedge clk);
    check8("R7 updated one cycle", {7'd0, updated}, 8'h00);

    for (int a = 0; a < 96; a++) if (mapped(a)) wr(a, 8'(a) ^ 8'hC3);
    check_outs("R1 restaged");

    wr(96, 8'h37);
    check8("R3 R7 updated after phase", {7'd0, updated}, 8'h01);
    check_outs("R3 phase commit");
    check_rd("R3 R4 phase readback");

    wr(41, 8'hEE);
    check_outs("R1 single load");
    wr(97, 8'h00);
    check8("R2 second apply pulse", {7'd0, updated}, 8'h01);
    wr(97, 8'hFF);
    check8("R7 back to back apply", {7'd0, updated}, 8'h01);
    check_outs("R2 back to back apply");

    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    for (int a = 0; a < 256; a++) begin m_sh[a] = '0; m_act[a] = '0; end
    m_ph_sh = '0; m_ph_act = '0;
    check8("R8 updated after second reset", {7'd0, updated}, 8'h00);
    check_outs("R8 second reset");
    check_rd("R8 second reset");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule